// File: doc/BRIEF.md
# Low-Power Compare Counter

This block is a counter with a match register, meant to sit behind a prescaler and a glitch filter in a low-power timer. Every cycle it picks one increment strobe out of four, based on two configuration choices. The first choice is whether the block counts time or counts pulses. The second is whether the time strobe comes straight from the prescaler clock or through its divider, and whether the pulse strobe is raw or filtered. The count advances by one for each accepted strobe. The divider and the filter are outside the block. Only their strobes arrive here.

A match event happens when the counter already holds the match value and an accepted strobe arrives. A match event does three things. It sets a sticky match flag. It emits a one-cycle trigger. It drives the interrupt when interrupt-enable is set. In reset-on-match operation the counter then returns to zero. In free-running operation it keeps climbing and wraps through zero. While the timer is enabled, software can only replace the match value while the flag is set. This keeps the counter from skipping past a value that changes under it. A debug halt freezes time counting but lets pulse counting continue.

Top module: `pulse_time_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `count` is 0 and `match_flag`, `irq` and `trig` are 0.
- R2: With `en` high, the counter adds one for each accepted strobe. The selection is as follows: `mode_pulse`=0 with `presc_bypass`=1 takes `tick_pclk`; `mode_pulse`=0 with `presc_bypass`=0 takes `tick_pout`; `mode_pulse`=1 with `filt_bypass`=1 takes `pulse_raw`; `mode_pulse`=1 with `filt_bypass`=0 takes `pulse_filt`. Strobes that are not selected have no effect.
- R3: While `en` is low, the counter is 0 one cycle later and stays there, and the match flag is cleared.
- R4: An accepted strobe that arrives while `count` equals the match value is a match event. After that clock edge `match_flag` is 1, and `trig` is 1 for that one cycle only.
- R5: With the free-run bit clear, a match event returns `count` to 0. After N accepted strobes from zero, the count is N mod (match+1).
- R6: With the free-run bit set, a match event does not disturb counting. After N strobes from zero, the count is N, and the flag is set exactly when N exceeds the match value.
- R7: A control write (`wr_sel`=1) uses `wr_data[0]` as interrupt-enable and `wr_data[1]` as free-run, and clears the flag when `wr_data[2]` is 1. A match event in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly when the match flag and interrupt-enable are both set.
- R9: A match-value write (`wr_sel`=0) is accepted while `en` is low or the flag is set. While `en` is high and the flag is clear, the write is ignored.
- R10: When `dbg_halt` is high, time-mode strobes are not counted. Pulse-mode strobes are still counted.
- R11: From 0xFFFF an accepted strobe takes the counter to 0. That strobe is a match event when the match value is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Timer enable |
| mode_pulse | input | 1 | 1 selects pulse counting, 0 selects time counting |
| presc_bypass | input | 1 | Time mode: 1 counts prescaler clock ticks, 0 counts divider output ticks |
| filt_bypass | input | 1 | Pulse mode: 1 counts raw strobes, 0 counts filtered strobes |
| dbg_halt | input | 1 | Debug halt request |
| tick_pclk | input | 1 | Prescaler clock strobe |
| tick_pout | input | 1 | Prescaler divider output strobe |
| pulse_raw | input | 1 | Unfiltered pulse strobe |
| pulse_filt | input | 1 | Filtered pulse strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 writes the match value, 1 writes the control fields |
| wr_data | input | WIDTH | Write data |
| count | output | WIDTH | Counter value |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt |
| trig | output | 1 | One-cycle match trigger |

## Verification
The hardest state to reach is the counter wrap. It takes 65,535 accepted strobes before the counter reaches 0xFFFF. The bench holds the prescaler-clock strobe high in free-run mode with the match value at 0xFFFF. It checks the all-ones value and then the wrap edge, where the wrap and a match event fall together. A second hard case is a compare write that lands while the flag is clear. The bench checks it by counting on with the old match value: the count keeps rising past the rejected value.

// File: rtl/pulse_time_counter.sv
module pulse_time_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_pulse,
  input  logic             presc_bypass,
  input  logic             filt_bypass,
  input  logic             dbg_halt,
  input  logic             tick_pclk,
  input  logic             tick_pout,
  input  logic             pulse_raw,
  input  logic             pulse_filt,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] count,
  output logic             match_flag,
  output logic             irq,
  output logic             trig
);

  localparam int IE_BIT  = 0;
  localparam int FR_BIT  = 1;
  localparam int CLR_BIT = 2;

  logic [WIDTH-1:0] count_q, match_q;
  logic             flag_q, irq_en_q, free_run_q, trig_q;

  logic time_tick, pulse_tick, step, hit, ctrl_wr, match_wr;

  assign time_tick  = presc_bypass ? tick_pclk : tick_pout;
  assign pulse_tick = filt_bypass ? pulse_raw : pulse_filt;
  assign step       = en & (mode_pulse ? pulse_tick : (time_tick & ~dbg_halt));
  assign hit        = step & (count_q == match_q);
  assign ctrl_wr    = wr_en & wr_sel;
  assign match_wr   = wr_en & ~wr_sel & (~en | flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!en) begin
      count_q <= '0;
    end else if (step) begin
      if (hit && !free_run_q) count_q <= '0;
      else                    count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (!en) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (ctrl_wr && wr_data[CLR_BIT]) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= 1'b0;
      free_run_q <= 1'b0;
    end else if (ctrl_wr) begin
      irq_en_q   <= wr_data[IE_BIT];
      free_run_q <= wr_data[FR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '0;
    else if (match_wr) match_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= hit;
  end

  assign count      = count_q;
  assign match_flag = flag_q;
  assign irq        = flag_q & irq_en_q;
  assign trig       = trig_q;

endmodule

// File: rtl/pulse_time_counter_chk.sv
module pulse_time_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode_pulse,
  input logic             dbg_halt,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [WIDTH-1:0] count,
  input logic             match_flag,
  input logic             irq,
  input logic             trig,
  input logic [WIDTH-1:0] match_q,
  input logic             free_run_q
);

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0) && !match_flag);

  assert_trig_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> match_flag);

  assert_reset_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !free_run_q) |-> (count == '0));

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> match_flag);

  assert_match_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !match_flag && wr_en && !wr_sel) |=> $stable(match_q));

  assert_time_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_pulse && dbg_halt) |=> $stable(count));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(count) || (count == '0) || (count == $past(count) + 1'b1));

endmodule

bind pulse_time_counter pulse_time_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .mode_pulse (mode_pulse),
  .dbg_halt   (dbg_halt),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .count      (count),
  .match_flag (match_flag),
  .irq        (irq),
  .trig       (trig),
  .match_q    (match_q),
  .free_run_q (free_run_q)
);

// File: tb/test_pulse_time_counter.sv
module test_pulse_time_counter;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, mode_pulse = 1'b0, presc_bypass = 1'b1, filt_bypass = 1'b1, dbg_halt = 1'b0;
  logic tick_pclk = 1'b0, tick_pout = 1'b0, pulse_raw = 1'b0, pulse_filt = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic match_flag, irq, trig;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pulse_time_counter #(.WIDTH(W)) i_pulse_time_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_pulse(mode_pulse),
    .presc_bypass(presc_bypass), .filt_bypass(filt_bypass), .dbg_halt(dbg_halt),
    .tick_pclk(tick_pclk), .tick_pout(tick_pout), .pulse_raw(pulse_raw),
    .pulse_filt(pulse_filt), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .match_flag(match_flag), .irq(irq), .trig(trig)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic ctrl(input logic ie, input logic fr, input logic clr);
    wr(1'b1, {{(W-3){1'b0}}, clr, fr, ie});
  endtask

  task automatic restart(input logic [W-1:0] m);
    en = 1'b0;
    step();
    wr(1'b0, m);
    en = 1'b1;
  endtask

  task automatic ticks(input int n);
    tick_pclk = 1'b1;
    repeat (n) step();
    tick_pclk = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mv[5] = '{0, 1, 2, 5, 9};
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flag", match_flag, 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 count after release", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 trig", trig, 0);

    // R2/R10: source selection sweep, with and without debug halt
    for (int sel = 0; sel < 4; sel++) begin
      for (int h = 0; h < 2; h++) begin
        for (int s = 0; s < 4; s++) begin
          int want_idx;
          int exp_n;
          mode_pulse = sel[1]; presc_bypass = sel[0]; filt_bypass = sel[0];
          restart('1);
          dbg_halt = h[0];
          want_idx = sel[1] ? (sel[0] ? 2 : 3) : (sel[0] ? 0 : 1);
          exp_n = (s == want_idx && !(h == 1 && sel[1] == 0)) ? 3 : 0;
          tick_pclk = (s == 0); tick_pout = (s == 1);
          pulse_raw = (s == 2); pulse_filt = (s == 3);
          repeat (3) step();
          tick_pclk = 0; tick_pout = 0; pulse_raw = 0; pulse_filt = 0;
          dbg_halt = 1'b0;
          if (h == 1) chk("R10 halt source sweep", count, exp_n);
          else        chk("R2 source sweep", count, exp_n);
        end
      end
    end
    mode_pulse = 1'b0; presc_bypass = 1'b1; filt_bypass = 1'b1;

    // R3: disable clears counter and flag
    restart(2);
    ticks(5);
    chk("R3 flag before disable", match_flag, 1);
    en = 1'b0;
    tick_pclk = 1'b1;
    step();
    step();
    tick_pclk = 1'b0;
    chk("R3 count disabled", count, 0);
    chk("R3 flag disabled", match_flag, 0);

    // R5/R6 sweeps over match value and strobe count
    for (int fr = 0; fr < 2; fr++) begin
      for (int k = 0; k < 5; k++) begin
        for (int n = 0; n <= 12; n++) begin
          restart(mv[k]);
          ctrl(1'b0, fr[0], 1'b0);
          ticks(n);
          if (fr == 0) begin
            chk("R5 count mod", count, n % (mv[k] + 1));
            chk("R5 flag", match_flag, n > mv[k]);
          end else begin
            chk("R6 free count", count, n);
            chk("R6 flag", match_flag, n > mv[k]);
          end
        end
      end
    end
    ctrl(1'b0, 1'b0, 1'b0);

    // R4: trigger is one cycle, aligned with flag set
    restart(3);
    ticks(3);
    chk("R4 trig before hit", trig, 0);
    tick_pclk = 1'b1;
    step();
    tick_pclk = 1'b0;
    chk("R4 trig on hit", trig, 1);
    chk("R4 flag on hit", match_flag, 1);
    step();
    chk("R4 trig one cycle", trig, 0);

    // R7/R8: clear and interrupt enable
    restart(2);
    ticks(2);
    tick_pclk = 1'b1;
    ctrl(1'b1, 1'b0, 1'b1);
    tick_pclk = 1'b0;
    chk("R7 set wins over clear", match_flag, 1);
    chk("R8 irq enabled", irq, 1);
    ctrl(1'b0, 1'b0, 1'b0);
    chk("R8 irq masked", irq, 0);
    chk("R7 no clear without bit", match_flag, 1);
    ctrl(1'b1, 1'b0, 1'b1);
    chk("R7 cleared", match_flag, 0);
    chk("R8 irq low when flag clear", irq, 0);
    ctrl(1'b0, 1'b0, 1'b0);

    // R9: match write gated by flag while enabled
    restart(9);
    wr(1'b0, 3);
    ticks(5);
    chk("R9 ignored write count", count, 5);
    chk("R9 ignored write flag", match_flag, 0);
    ticks(5);
    chk("R9 old match hit", match_flag, 1);
    chk("R9 count after hit", count, 0);
    wr(1'b0, 3);
    ctrl(1'b0, 1'b0, 1'b1);
    ticks(3);
    chk("R9 new match count", count, 3);
    chk("R9 new match no flag", match_flag, 0);
    ticks(1);
    chk("R9 new match hit", match_flag, 1);
    chk("R9 new match reset", count, 0);

    // R11: wrap through all ones
    restart('1);
    ctrl(1'b0, 1'b1, 1'b0);
    ticks(65535);
    chk("R11 all ones", count, 65535);
    chk("R11 no flag yet", match_flag, 0);
    ticks(1);
    chk("R11 wrapped", count, 0);
    chk("R11 wrap match flag", match_flag, 1);
    chk("R11 wrap trig", trig, 1);

    finish_run();
  end
endmodule